// File: doc/BRIEF.md
# Serial Byte Transmitter (8N1)

This block turns bytes from an on-chip producer into an asynchronous serial stream on one output line. Each character has a low start bit, eight data bits and one high stop bit, with no parity. Between characters the line rests high. Bit timing comes from a separate baud generator. That generator delivers a one-cycle `bit_tick` pulse once per bit period, and every level change on the line lines up with such a pulse.

The producer places a byte on `tx_data` and raises `tx_stb`. The byte is taken on a tick edge where the transmitter is free, and the start bit goes out on that same edge. The cycle after, `tx_ack` pulses for one clock. The acknowledge therefore marks the start of the character, not its end. A producer that wants a single character must lower its strobe the cycle after it sees the acknowledge. A strobe still high when the stop bit ends is taken as a new request, and the next character follows the stop bit with no idle gap.

Top module: `sertx_core`

## Requirements
- R1: While `rst` (active high) is asserted, and after it is released until a byte is accepted, `tx_line` is 1 and `tx_ack` is 0, whatever `tx_stb`, `tx_data` and `bit_tick` do.
- R2: A byte is accepted only on a clock edge where `bit_tick` and `tx_stb` are both 1 and the transmitter is idle or finishing its stop bit. `tx_ack` is 1 for exactly the one cycle after that edge.
- R3: A character is a 0 start bit, then the data bits with bit 0 first, then a 1 stop bit. The start bit appears on the accepting edge. Each later bit appears on the next tick edge, so every bit lasts exactly one tick period.
- R4: `tx_line` changes only on clock edges where `bit_tick` is 1.
- R5: If the strobe is lowered the cycle after `tx_ack`, exactly one character is sent, and the line then stays at 1.
- R6: If `tx_stb` is 1 on the tick that ends a stop bit, the byte on `tx_data` is accepted there. Its start bit replaces the idle level at once, and a new `tx_ack` pulse follows.
- R7: During a character, changes on `tx_data` and a strobe raised before the stop bit ends, even across a tick, change neither the bits sent nor `tx_ack`.
- R8: Two accepting edges are always at least ten tick edges apart, counting the second one. No byte is taken before the stop bit has lasted a full tick period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_tick | input | 1 | One-cycle pulse per bit period from the baud generator |
| tx_data | input | DATA_W (8) | Byte offered by the producer |
| tx_stb | input | 1 | Producer request: byte on `tx_data` is valid |
| tx_ack | output | 1 | One-cycle pulse: byte accepted, start bit on the line |
| tx_line | output | 1 | Serial output, idle high |

## Verification
The assertions check on every cycle that the line moves only on tick edges, that each acknowledge is a single pulse that follows a tick-and-strobe edge with the start bit on the line, and that accepting edges are never closer than one full frame of ticks. They also check that the line stays high through reset. Only the bench scenarios show that every byte value comes out with the right bit order and stop level, and that dropping the strobe after the acknowledge gives exactly one character. The same scenarios show that a held strobe chains characters with no gap, and that strobe pulses and data changes in mid-character leave the frame alone.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  typedef enum logic {
    TXS_IDLE = 1'b0,
    TXS_BUSY = 1'b1
  } txs_e;

  // Level of slot 'pos' in a frame: slot 0 start, 1..dw data LSB first,
  // any later slot the stop level. Data widths up to 16 are supported.
  function automatic logic frame_bit(input logic [15:0] word,
                                     input int unsigned dw,
                                     input int unsigned pos);
    logic lvl;
    if (pos == 0)
      lvl = 1'b0;
    else if (pos <= dw)
      lvl = word[pos - 1];
    else
      lvl = 1'b1;
    return lvl;
  endfunction

  // Slots in one frame: start + data + one stop.
  function automatic int unsigned frame_slots(input int unsigned dw);
    return dw + 2;
  endfunction

endpackage

// File: rtl/sertx_seq.sv
module sertx_seq
  import sertx_pkg::*;
#(
  parameter int unsigned FRAME_LEN = 10,
  parameter int unsigned IDX_W     = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_tick,
  input  logic             tx_stb,
  output logic             cap_evt,
  output logic             busy,
  output logic             last_slot,
  output logic [IDX_W-1:0] slot_idx
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);

  txs_e             st_q;
  logic [IDX_W-1:0] idx_q;
  logic             eligible;

  assign busy      = (st_q == TXS_BUSY);
  assign last_slot = busy && (idx_q == LAST_IDX);
  assign eligible  = !busy || last_slot;
  assign cap_evt   = bit_tick && tx_stb && eligible;
  assign slot_idx  = idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= TXS_IDLE;
      idx_q <= '0;
    end else if (bit_tick) begin
      if (eligible) begin
        idx_q <= '0;
        st_q  <= tx_stb ? TXS_BUSY : TXS_IDLE;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
  import sertx_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_tick,
  input  logic              cap_evt,
  input  logic              busy,
  input  logic              last_slot,
  input  logic [IDX_W-1:0]  slot_idx,
  input  logic [DATA_W-1:0] din,
  output logic              line
);

  logic [DATA_W-1:0] byte_q;
  logic [15:0]       word;
  logic              line_q;
  logic              line_next;

  assign word = 16'(byte_q);

  always_comb begin
    if (cap_evt)
      line_next = 1'b0;
    else if (busy && !last_slot)
      line_next = frame_bit(word, DATA_W, int'(slot_idx) + 1);
    else
      line_next = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      byte_q <= '0;
      line_q <= 1'b1;
    end else begin
      if (cap_evt)
        byte_q <= din;
      if (bit_tick)
        line_q <= line_next;
    end
  end

  assign line = line_q;

endmodule

// File: rtl/sertx_core.sv
module sertx_core
  import sertx_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_tick,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_stb,
  output logic              tx_ack,
  output logic              tx_line
);

  localparam int unsigned FRAME_LEN = frame_slots(DATA_W);
  localparam int unsigned IDX_W     = $clog2(FRAME_LEN);

  logic             cap_evt;
  logic             busy;
  logic             last_slot;
  logic [IDX_W-1:0] slot_idx;
  logic             ack_q;

  sertx_seq #(
    .FRAME_LEN(FRAME_LEN),
    .IDX_W    (IDX_W)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .bit_tick (bit_tick),
    .tx_stb   (tx_stb),
    .cap_evt  (cap_evt),
    .busy     (busy),
    .last_slot(last_slot),
    .slot_idx (slot_idx)
  );

  sertx_shift #(
    .DATA_W(DATA_W),
    .IDX_W (IDX_W)
  ) u_shift (
    .clk      (clk),
    .rst      (rst),
    .bit_tick (bit_tick),
    .cap_evt  (cap_evt),
    .busy     (busy),
    .last_slot(last_slot),
    .slot_idx (slot_idx),
    .din      (tx_data),
    .line     (tx_line)
  );

  always_ff @(posedge clk) begin
    if (rst) ack_q <= 1'b0;
    else     ack_q <= cap_evt;
  end

  assign tx_ack = ack_q;

endmodule

// File: rtl/sertx_core_chk.sv
module sertx_core_chk #(
  parameter int unsigned FRAME_LEN = 10
) (
  input logic clk,
  input logic rst,
  input logic bit_tick,
  input logic tx_stb,
  input logic tx_ack,
  input logic tx_line,
  input logic cap_evt
);

  localparam int unsigned CW = $clog2(FRAME_LEN + 1);

  logic [CW-1:0] ticks_since;
  logic          rst_d;

  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst)
      ticks_since <= '0;
    else if (cap_evt)
      ticks_since <= CW'(1);
    else if (bit_tick && ticks_since != '0 && ticks_since < CW'(FRAME_LEN))
      ticks_since <= ticks_since + 1'b1;
  end

  // R1: line held high while reset was sampled
  always @(negedge clk) begin
    if (rst_d) a_r1_idle_in_reset: assert (tx_line == 1'b1);
  end

  a_r4_line_moves_on_tick: assert property (@(posedge clk) disable iff (rst)
    !bit_tick |=> $stable(tx_line));

  a_r2_ack_single_pulse: assert property (@(posedge clk) disable iff (rst)
    tx_ack |=> !tx_ack);

  a_r2_ack_after_tick_strobe: assert property (@(posedge clk) disable iff (rst)
    tx_ack |-> $past(bit_tick && tx_stb));

  a_r2_capture_then_ack: assert property (@(posedge clk) disable iff (rst)
    cap_evt |=> tx_ack);

  a_r3_start_low_at_ack: assert property (@(posedge clk) disable iff (rst)
    tx_ack |-> !tx_line);

  a_r8_frame_spacing: assert property (@(posedge clk) disable iff (rst)
    cap_evt |-> (ticks_since == '0 || ticks_since == CW'(FRAME_LEN)));

endmodule

bind sertx_core sertx_core_chk #(.FRAME_LEN(FRAME_LEN)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .bit_tick(bit_tick),
  .tx_stb  (tx_stb),
  .tx_ack  (tx_ack),
  .tx_line (tx_line),
  .cap_evt (cap_evt)
);

// File: tb/sertx_core_bench.sv
module sertx_core_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_tick = 1'b0;
  logic       tx_stb = 1'b0;
  logic [7:0] tx_data = 8'h00;
  wire        tx_ack;
  wire        tx_line;

  sertx_core u_sertx_core (
    .clk     (clk),
    .rst     (rst),
    .bit_tick(bit_tick),
    .tx_data (tx_data),
    .tx_stb  (tx_stb),
    .tx_ack  (tx_ack),
    .tx_line (tx_line)
  );

  always #2 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  int tdiv  = 4;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // tick source, one pulse every tdiv cycles
  initial begin
    int c;
    c = 0;
    forever begin
      @(negedge clk);
      c++;
      if (c >= tdiv) c = 0;
      bit_tick = (c == 0);
    end
  end

  logic tick_seen = 1'b0;
  always @(posedge clk) tick_seen <= bit_tick;

  // line monitor / frame decoder
  int        mon_st = 0;
  int        bitn = 0;
  logic [7:0] cur = 8'h00;
  int        idle_cnt = 0;
  int        got = 0;
  logic [7:0] got_b [0:511];
  int        gaps [0:511];
  int        tick_cnt = 0;
  int        acks = 0;
  int        ack_tick [0:511];
  logic      prev_line = 1'b1;

  always @(negedge clk) begin
    if (!rst) begin
      if (!tick_seen && tx_line !== prev_line)
        chk(1'b0, "R4 line moved without tick", int'(tx_line), int'(prev_line));
      if (tick_seen) begin
        tick_cnt++;
        case (mon_st)
          0: if (tx_line == 1'b0) begin
               mon_st = 1; bitn = 0; gaps[got] = idle_cnt;
             end else idle_cnt++;
          1: begin
               cur[bitn] = tx_line;
               bitn++;
               if (bitn == 8) mon_st = 2;
             end
          default: begin
               chk(tx_line == 1'b1, "R3 stop level", int'(tx_line), 1);
               got_b[got] = cur;
               got++;
               mon_st = 0;
               idle_cnt = 0;
             end
        endcase
      end
      if (tx_ack) begin
        ack_tick[acks] = tick_cnt;
        acks++;
      end
    end
    prev_line = tx_line;
  end

  logic [7:0] exp_b [0:511];
  int         ne = 0;

  task automatic wait_ack();
    int w;
    w = 0;
    while (!tx_ack && w < 1000) begin
      @(negedge clk);
      w++;
    end
    chk(w < 1000, "R2 acknowledge arrives", w, 0);
  endtask

  task automatic wait_quiet();
    int w;
    w = 0;
    while ((got != ne || mon_st != 0) && w < 2000) begin
      @(negedge clk);
      w++;
    end
    repeat (3 * tdiv + 2) @(negedge clk);
  endtask

  // offer b, drop strobe one cycle after acknowledge, scramble data bus
  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    tx_data = b;
    tx_stb  = 1'b1;
    exp_b[ne] = b;
    ne++;
    wait_ack();
    chk(tx_line == 1'b0, "R2 start bit with acknowledge", int'(tx_line), 0);
    @(negedge clk);
    chk(!tx_ack, "R2 acknowledge one cycle", int'(tx_ack), 0);
    tx_stb  = 1'b0;
    tx_data = ~b;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    bit ok;
    int fs;
    int a0;
    // R1: reset ignores strobe and ticks
    tx_stb = 1'b1;
    ok = 1'b1;
    repeat (20) @(negedge clk) ok &= (tx_line == 1'b1) && (tx_ack == 1'b0);
    chk(ok, "R1 outputs during reset", int'(ok), 1);
    tx_stb = 1'b0;
    rst = 1'b0;
    ok = 1'b1;
    repeat (40) @(negedge clk) ok &= (tx_line == 1'b1) && (tx_ack == 1'b0);
    chk(ok, "R1 idle after reset", int'(ok), 1);
    chk(acks == 0, "R1 no acknowledge after reset", acks, 0);

    // R3 / R5: every byte value, strobe dropped after acknowledge
    tdiv = 4;
    for (int b = 0; b < 256; b++) send_byte(8'(b));
    wait_quiet();
    chk(got == ne, "R5 one frame per request", got, ne);
    chk(acks == ne, "R5 one acknowledge per request", acks, ne);
    for (int i = 0; i < 256; i++)
      chk(got_b[i] == exp_b[i], "R3 frame content", int'(got_b[i]), int'(exp_b[i]));
    chk(tx_line == 1'b1, "R5 line idle after last frame", int'(tx_line), 1);

    // R6 / R8: strobe held, frames chained
    tdiv = 3;
    fs = ne;
    @(negedge clk);
    tx_data = 8'hA5;
    tx_stb  = 1'b1;
    exp_b[ne] = 8'hA5; ne++;
    for (int k = 0; k < 5; k++) begin
      wait_ack();
      @(negedge clk);
      tx_data = 8'(8'h1E * (k + 1) + 8'h07);
      exp_b[ne] = tx_data; ne++;
    end
    wait_ack();
    @(negedge clk);
    tx_stb = 1'b0;
    wait_quiet();
    chk(got == ne, "R6 chained frame count", got, ne);
    for (int i = fs; i < ne; i++)
      chk(got_b[i] == exp_b[i], "R6 chained frame content", int'(got_b[i]), int'(exp_b[i]));
    for (int i = fs + 1; i < ne; i++) begin
      chk(gaps[i] == 0, "R6 no idle between chained frames", gaps[i], 0);
      chk(ack_tick[i] - ack_tick[i-1] == 10, "R8 acknowledge spacing", ack_tick[i] - ack_tick[i-1], 10);
    end

    // R7: strobe across a mid-frame tick and data changes are ignored
    tdiv = 7;
    send_byte(8'hC3);
    while (!(mon_st == 1 && bitn >= 4)) @(negedge clk);
    a0 = acks;
    tx_stb  = 1'b1;
    tx_data = 8'h5A;
    repeat (tdiv + 1) @(negedge clk);
    tx_stb = 1'b0;
    wait_quiet();
    chk(acks == a0, "R7 mid-frame strobe ignored", acks, a0);
    chk(got == ne, "R7 frame count", got, ne);
    chk(got_b[ne-1] == 8'hC3, "R7 captured byte kept", int'(got_b[ne-1]), 'hC3);
    finish_run();
  end

endmodule